// File: doc/BRIEF.md
# Shared-Bus Register File with Word Memory

This block holds four general registers that all talk over a single internal bus. A two-bit select code picks which register drives the bus. Every register can capture the bus value on the next rising clock edge, either as a whole word or one half at a time. Because each half has its own load strobe, one transfer can copy a full word, only the upper half, or only the lower half. When several registers are enabled together, they all take the same value.

A small word memory is attached to the same bus through an address register. The address register loads from the low bits of the bus. A write stores the current bus value at the word the address register points to. A read moves that word into the fourth register. The fourth register also has a direct external load, which is the only way new data enters the block.

A bus enable gates the whole bus. While it is low, no register drives the bus and the bus reads as all zeros. A parameter picks how the bus is built: a one-hot decoder gating an AND-OR tree, or one four-input multiplexer per bus bit. The two structures behave identically at the ports.

Top module: `cbus_regfile_sys`

## Requirements
- R1: With `bus_en` high, `bus_sel` code 0 places register A on `bus_o`, code 1 register B, code 2 register C and code 3 register D. The register file output `regs_o` holds A in bits [15:0], B in [31:16], C in [47:32] and D in [63:48].
- R2: With `bus_en` low, `bus_o` is all zeros. A register loaded in that cycle captures zeros.
- R3: A register changes only at the rising edge that ends a cycle in which one of its load strobes is high. With no strobe it keeps its value.
- R4: Strobe `ld_hi[k]` loads bits [15:8] of register k from the same bits of the bus, and `ld_lo[k]` loads bits [7:0]. Bit k of each strobe vector refers to register k (0=A … 3=D). Either strobe alone leaves the other half unchanged.
- R5: When several registers are strobed in one cycle, all of them capture the same bus value. This includes the register that is driving the bus.
- R6: `ld_ar` loads the address register (`ar_o`) from the low 4 bits of the bus at the clock edge.
- R7: `mem_rd` with `mem_wr` low loads register D with the memory word addressed by the address register's value before the edge. This load overrides `ext_ld` and the bus strobes of D.
- R8: `mem_wr` stores the bus value into the word addressed by the address register's value before the edge. When `mem_rd` and `mem_wr` are both high, only the write happens and D is not loaded from memory.
- R9: Synchronous reset clears registers A to D and the address register to zero. Memory contents survive reset, and no write occurs while reset is high.
- R10: `ext_ld` loads register D with `ext_data` at the clock edge. It takes priority over D's bus strobes, but a memory read takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 2 | Register driving the bus (0=A, 1=B, 2=C, 3=D) |
| bus_en | input | 1 | Bus enable; low leaves the bus undriven (reads zero) |
| ld_hi | input | 4 | Per-register upper-half load strobes |
| ld_lo | input | 4 | Per-register lower-half load strobes |
| ld_ar | input | 1 | Address register load from the bus |
| mem_rd | input | 1 | Memory read into register D |
| mem_wr | input | 1 | Memory write of the bus value |
| ext_ld | input | 1 | External load of register D |
| ext_data | input | 16 | External data for register D |
| bus_o | output | 16 | Current bus value |
| regs_o | output | 64 | Registers A..D, A in the low word |
| ar_o | output | 4 | Address register |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edges have passed. They also assume that every control input is stable around the rising edge and never unknown outside reset. The memory-read assertion further assumes that the addressed word has been written at least once, so that it holds defined data. The bench meets these assumptions by changing inputs only at falling edges and by holding reset for two cycles at the start. Before any read, it writes every memory word through the bus, so all later reads, including the one after the mid-run reset, see defined data.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
   localparam int NUM_REGS = 4;
   localparam int SEL_W    = 2;
   typedef enum logic [SEL_W-1:0] {
      SRC_A = 2'd0,
      SRC_B = 2'd1,
      SRC_C = 2'd2,
      SRC_D = 2'd3
   } bus_src_e;
   localparam int D_IDX = 3;
endpackage

// File: rtl/cbus_select.sv
module cbus_select #(
   parameter int DATA_W      = 16,
   parameter int NREG        = 4,
   parameter bit USE_DECODER = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [1:0]             sel,
   input  logic                   en,
   input  logic [NREG*DATA_W-1:0] regs_flat,
   output logic [DATA_W-1:0]      bus
);
   if (NREG != 4) begin : g_bad_nreg
      $error("cbus_select expects exactly four sources");
   end

   if (USE_DECODER) begin : g_dec
      logic [NREG-1:0] drive_en;
      always_comb begin
         drive_en = '0;
         if (en) drive_en[sel] = 1'b1;
      end
      always_comb begin
         bus = '0;
         for (int k = 0; k < NREG; k++)
            bus = bus | ({DATA_W{drive_en[k]}} & regs_flat[k*DATA_W +: DATA_W]);
      end
      assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
         en |-> $countones(drive_en) == 1);
      assert_nodrive_R2: assert property (@(posedge clk) disable iff (rst)
         !en |-> drive_en == '0);
   end else begin : g_mux
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic pick;
         always_comb begin
            case (sel)
               2'd0:    pick = regs_flat[0*DATA_W + i];
               2'd1:    pick = regs_flat[1*DATA_W + i];
               2'd2:    pick = regs_flat[2*DATA_W + i];
               default: pick = regs_flat[3*DATA_W + i];
            endcase
         end
         assign bus[i] = pick & en;
      end
   end
endmodule

// File: rtl/cbus_reg.sv
module cbus_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_hi,
   input  logic              ld_lo,
   input  logic [DATA_W-1:0] d,
   input  logic              alt_ld,
   input  logic [DATA_W-1:0] alt_d,
   output logic [DATA_W-1:0] q
);
   localparam int HALF = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_bad_w
      $error("cbus_reg width must be even");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (alt_ld) begin
         q <= alt_d;
      end else begin
         if (ld_hi) q[DATA_W-1:HALF] <= d[DATA_W-1:HALF];
         if (ld_lo) q[HALF-1:0]      <= d[HALF-1:0];
      end
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!ld_hi && !ld_lo && !alt_ld) |=> $stable(q));
   assert_hi_only_R4: assert property (@(posedge clk) disable iff (rst)
      (ld_hi && !ld_lo && !alt_ld) |=>
         (q[HALF-1:0] == $past(q[HALF-1:0]) && q[DATA_W-1:HALF] == $past(d[DATA_W-1:HALF])));
   assert_lo_only_R4: assert property (@(posedge clk) disable iff (rst)
      (ld_lo && !ld_hi && !alt_ld) |=>
         (q[DATA_W-1:HALF] == $past(q[DATA_W-1:HALF]) && q[HALF-1:0] == $past(d[HALF-1:0])));
endmodule

// File: rtl/cbus_mem.sv
module cbus_mem #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
      $error("cbus_mem depth out of range");
   end

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) words[addr] <= wdata;
   end

   assign rdata = words[addr];

   assert_wr_R8: assert property (@(posedge clk)
      (wr_en && $stable(addr)) |=> rdata == $past(wdata));
endmodule

// File: rtl/cbus_regfile_sys.sv
module cbus_regfile_sys #(
   parameter int DATA_W      = 16,
   parameter int MEM_DEPTH   = 16,
   parameter bit USE_DECODER = 1'b1,
   localparam int NREG   = cbus_pkg::NUM_REGS,
   localparam int ADDR_W = $clog2(MEM_DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [1:0]             bus_sel,
   input  logic                   bus_en,
   input  logic [NREG-1:0]        ld_hi,
   input  logic [NREG-1:0]        ld_lo,
   input  logic                   ld_ar,
   input  logic                   mem_rd,
   input  logic                   mem_wr,
   input  logic                   ext_ld,
   input  logic [DATA_W-1:0]      ext_data,
   output logic [DATA_W-1:0]      bus_o,
   output logic [NREG*DATA_W-1:0] regs_o,
   output logic [ADDR_W-1:0]      ar_o
);
   import cbus_pkg::*;

   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("address wider than the bus");
   end

   logic [DATA_W-1:0] bus;
   logic [DATA_W-1:0] mem_rdata;
   logic              rd_fire;
   logic              wr_fire;
   logic [ADDR_W-1:0] ar_q;

   assign wr_fire = mem_wr && !rst;
   assign rd_fire = mem_rd && !mem_wr;

   cbus_select #(.DATA_W(DATA_W), .NREG(NREG), .USE_DECODER(USE_DECODER)) u_sel (
      .clk(clk), .rst(rst), .sel(bus_sel), .en(bus_en),
      .regs_flat(regs_o), .bus(bus)
   );

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic              alt_ld;
      logic [DATA_W-1:0] alt_d;
      if (k == D_IDX) begin : g_data_reg
         assign alt_ld = rd_fire || ext_ld;
         assign alt_d  = rd_fire ? mem_rdata : ext_data;
      end else begin : g_plain
         assign alt_ld = 1'b0;
         assign alt_d  = '0;
      end
      cbus_reg #(.DATA_W(DATA_W)) u_reg (
         .clk(clk), .rst(rst), .ld_hi(ld_hi[k]), .ld_lo(ld_lo[k]),
         .d(bus), .alt_ld(alt_ld), .alt_d(alt_d),
         .q(regs_o[k*DATA_W +: DATA_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst)        ar_q <= '0;
      else if (ld_ar) ar_q <= bus[ADDR_W-1:0];
   end

   cbus_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
      .clk(clk), .wr_en(wr_fire), .addr(ar_q), .wdata(bus), .rdata(mem_rdata)
   );

   assign bus_o = bus;
   assign ar_o  = ar_q;

   assert_sel_R1: assert property (@(posedge clk) disable iff (rst)
      bus_en |-> bus_o == regs_o[bus_sel*DATA_W +: DATA_W]);
   assert_float_R2: assert property (@(posedge clk) disable iff (rst)
      !bus_en |-> bus_o == '0);
   assert_ar_R6: assert property (@(posedge clk) disable iff (rst)
      ld_ar |=> ar_o == $past(bus_o[ADDR_W-1:0]));
   assert_read_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && !mem_wr) |=> regs_o[D_IDX*DATA_W +: DATA_W] == $past(mem_rdata));
   assert_rdwr_R8: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && mem_wr && !ext_ld && !ld_hi[D_IDX] && !ld_lo[D_IDX]) |=>
         $stable(regs_o[D_IDX*DATA_W +: DATA_W]));
   assert_reset_R9: assert property (@(posedge clk)
      rst |=> (regs_o == '0 && ar_o == '0));
   assert_ext_R10: assert property (@(posedge clk) disable iff (rst)
      (ext_ld && !mem_rd) |=> regs_o[D_IDX*DATA_W +: DATA_W] == $past(ext_data));
endmodule

// File: tb/tb_cbus_regfile_sys.sv
module tb_cbus_regfile_sys;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  bus_sel = '0;
   logic        bus_en = 1'b0;
   logic [3:0]  ld_hi = '0, ld_lo = '0;
   logic        ld_ar = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0, ext_ld = 1'b0;
   logic [15:0] ext_data = '0;
   logic [15:0] bus_o;
   logic [63:0] regs_o;
   logic [3:0]  ar_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [15:0] m_r [4];
   logic [3:0]  m_ar;
   logic [15:0] m_mem [16];

   cbus_regfile_sys dut (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en),
      .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_ar(ld_ar), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .ext_ld(ext_ld), .ext_data(ext_data),
      .bus_o(bus_o), .regs_o(regs_o), .ar_o(ar_o)
   );

   always #2 clk = ~clk;

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      bus_sel = '0; bus_en = 1'b0; ld_hi = '0; ld_lo = '0;
      ld_ar = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0; ext_ld = 1'b0; ext_data = '0;
   endtask

   // Inputs already set at a falling edge; runs one cycle and compares.
   task automatic step(string tag);
      logic [15:0] bus, nr [4];
      logic [3:0]  nar;
      #1;
      bus = bus_en ? m_r[bus_sel] : 16'h0;
      chk(tag, "bus", bus_o, bus);
      for (int k = 0; k < 4; k++) begin
         nr[k] = m_r[k];
         if (ld_hi[k]) nr[k][15:8] = bus[15:8];
         if (ld_lo[k]) nr[k][7:0]  = bus[7:0];
      end
      if (ext_ld) nr[3] = ext_data;
      if (mem_rd && !mem_wr) nr[3] = m_mem[m_ar];
      nar = ld_ar ? bus[3:0] : m_ar;
      if (rst) begin
         for (int k = 0; k < 4; k++) nr[k] = '0;
         nar = '0;
      end else if (mem_wr) begin
         m_mem[m_ar] = bus;
      end
      @(posedge clk);
      for (int k = 0; k < 4; k++) m_r[k] = nr[k];
      m_ar = nar;
      @(negedge clk);
      for (int k = 0; k < 4; k++) chk(tag, $sformatf("reg%0d", k), regs_o[k*16 +: 16], m_r[k]);
      chk(tag, "ar", {12'h0, ar_o}, {12'h0, m_ar});
      idle();
   endtask

   task automatic put_d(logic [15:0] v, string tag);
      ext_ld = 1'b1; ext_data = v; step(tag);
   endtask

   task automatic copy(logic [1:0] src, logic [3:0] hi, logic [3:0] lo, string tag);
      bus_en = 1'b1; bus_sel = src; ld_hi = hi; ld_lo = lo; step(tag);
   endtask

   initial begin
      for (int k = 0; k < 4; k++) m_r[k] = '0;
      m_ar = '0;
      idle();
      rst = 1'b1;
      @(negedge clk);
      step("R9_reset"); step("R9_reset");
      rst = 1'b0;
      // fill memory: address from D into AR, value into D, write
      for (int a = 0; a < 16; a++) begin
         put_d(16'(a) | 16'h0F50, "R10_ext");
         bus_en = 1'b1; bus_sel = 2'd3; ld_ar = 1'b1; step("R6_ar");
         put_d(16'hC300 ^ 16'(a * 16'h1111), "R10_ext");
         bus_en = 1'b1; bus_sel = 2'd3; mem_wr = 1'b1; step("R8_write");
      end
      // R1/R3 full copies through the bus
      put_d(16'h1234, "R10_ext");
      copy(2'd3, 4'b0001, 4'b0001, "R3_copy_to_A");
      put_d(16'h5678, "R10_ext");
      copy(2'd3, 4'b0010, 4'b0010, "R3_copy_to_B");
      put_d(16'h9ABC, "R10_ext");
      copy(2'd3, 4'b0100, 4'b0100, "R3_copy_to_C");
      for (int s = 0; s < 4; s++) begin
         bus_en = 1'b1; bus_sel = 2'(s); step("R1_select");
      end
      // R4 half loads
      copy(2'd0, 4'b0010, 4'b0000, "R4_hi_only");
      copy(2'd2, 4'b0000, 4'b0001, "R4_lo_only");
      // R5 broadcast, including the source itself
      copy(2'd1, 4'b0111, 4'b0111, "R5_multi");
      put_d(16'hFEDC, "R10_ext");
      copy(2'd3, 4'b1101, 4'b1101, "R5_multi_self");
      // R2 disabled bus loads zeros
      bus_en = 1'b0; bus_sel = 2'd3; ld_hi = 4'b0001; ld_lo = 4'b0001; step("R2_float");
      // R7 read, old AR used when AR loads in same cycle; beats ext and bus loads
      put_d(16'h0005, "R10_ext");
      bus_en = 1'b1; bus_sel = 2'd3; ld_ar = 1'b1; step("R6_ar");
      put_d(16'h000A, "R10_ext");
      bus_en = 1'b1; bus_sel = 2'd3; ld_ar = 1'b1; mem_rd = 1'b1; step("R7_read_old_ar");
      mem_rd = 1'b1; ext_ld = 1'b1; ext_data = 16'h7777;
      bus_en = 1'b1; bus_sel = 2'd1; ld_hi = 4'b1000; ld_lo = 4'b1000; step("R7_read_priority");
      // R8 read+write: write only, D follows bus strobes
      bus_en = 1'b1; bus_sel = 2'd1; mem_rd = 1'b1; mem_wr = 1'b1; step("R8_rdwr");
      mem_rd = 1'b1; step("R8_readback");
      put_d(16'h4444, "R10_ext");
      bus_en = 1'b1; bus_sel = 2'd0; mem_rd = 1'b1; mem_wr = 1'b1;
      ld_lo = 4'b1000; step("R8_rdwr_bus_load");
      // R10 ext beats bus strobes
      ext_ld = 1'b1; ext_data = 16'hBEEF; bus_en = 1'b1; bus_sel = 2'd0;
      ld_hi = 4'b1000; ld_lo = 4'b1000; step("R10_priority");
      // R9 reset mid-run, write blocked, memory kept
      rst = 1'b1; bus_en = 1'b1; bus_sel = 2'd3; mem_wr = 1'b1; step("R9_reset_mid");
      rst = 1'b0;
      mem_rd = 1'b1; step("R9_mem_kept");
      for (int s = 0; s < 4; s++) begin
         bus_en = 1'b1; bus_sel = 2'(s); step("R3_hold");
      end
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog run did not complete");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule